// File: doc/BRIEF.md
# Privileged Run-Length Predictor

This block estimates how many instructions a privileged-mode invocation is going to run, so that a policy elsewhere on the chip can decide whether offloading or reconfiguring for that invocation is worth the cost. On every switch into privileged mode, the core presents five 64-bit architected values and pulses an entry strobe. These values are the processor-state register, two global registers and two input-argument registers. The block folds them together with XOR. The low bits of the result select an entry in a direct-mapped table that has no tags. Each entry holds the length seen the last time that index was used and a two-bit confidence counter.

When the selected entry has a confidence of zero, the block does not trust it. It outputs the mean of the three most recently completed invocations instead, whatever their keys. Otherwise it outputs the stored length. When the invocation finishes, the core pulses an exit strobe with the measured length. The block then overwrites the stored length, moves the confidence one step up or down according to a ±5% test, and pushes the measured length into the global history. Only one invocation is outstanding at a time.

Top module: `osrl_predictor`

## Requirements
- R1: The table index is the low IDX_W bits (default 6) of the bitwise XOR of the five key inputs. Keys that share those bits share an entry, because there is no tag comparison.
- R2: `pred_vld` is high for exactly the one cycle after a cycle with `entry_vld` high. `pred_len` is updated at that same edge and holds its value until the next entry.
- R3: When the selected entry's confidence is 0, `pred_len` is the floor of the sum of the last three accepted exit lengths divided by three. History slots not yet filled count as 0.
- R4: When the selected entry's confidence is 1, 2 or 3, `pred_len` is the length stored in that entry.
- R5: An accepted exit writes `exit_len` into the entry that the outstanding entry selected, replacing the old length whatever the outcome of the confidence test.
- R6: On an accepted exit, confidence is incremented when 20·|P − A| ≤ A and decremented otherwise. P is the length that was output for that invocation and A is `exit_len`. Equality counts as a hit.
- R7: Confidence saturates at 3 going up and at 0 going down.
- R8: An `exit_vld` pulse with no outstanding entry changes no table entry and no history slot. An entry opens an invocation and an accepted exit closes it.
- R9: After reset, every confidence is 0, every stored length and history slot is 0, `pred_vld` is 0 and `pred_len` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_vld | input | 1 | Pulse on a switch into privileged mode |
| key_pstate | input | 64 | Processor-state register value at entry |
| key_glob0 | input | 64 | First global register value at entry |
| key_glob1 | input | 64 | Second global register value at entry |
| key_arg0 | input | 64 | First input-argument register value at entry |
| key_arg1 | input | 64 | Second input-argument register value at entry |
| pred_vld | output | 1 | One-cycle flag marking a fresh prediction |
| pred_len | output | 16 | Predicted run length in instructions |
| exit_vld | input | 1 | Pulse at the end of the privileged invocation |
| exit_len | input | 16 | Measured run length of the finished invocation |

## Verification
A vector table drives one index through confidence 0 with a history that is filling up. This separates the global mean (R3) from the stored length (R4). The same index is then taken up to saturation and back down, so the sequence of predictions exposes a counter that wraps instead of clamping (R7). Some exit lengths sit exactly on the 5% boundary and others one unit outside it, which separates a ≤ test from a < test (R6). Two further cases cover aliasing and stray exits. A key whose only differing bits lie above the index width must return the first key's length (R1). A stray exit carrying a large length is followed by a confidence-0 lookup, whose mean reveals whether the history was polluted (R8).

// File: rtl/osrl_pkg.sv
package osrl_pkg;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MIN = 2'd0;
    localparam conf_t CONF_MAX = 2'd3;

    // Saturating confidence step: up on hit, down on miss.
    function automatic conf_t conf_step(input conf_t cur, input logic hit);
        conf_t nxt;
        nxt = cur;
        if (hit) begin
            if (cur != CONF_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CONF_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/osrl_key_hash.sv
module osrl_key_hash #(
    parameter int KEY_W  = 64,
    parameter int NKEYS  = 5,
    parameter int IDX_W  = 6
) (
    input  logic [NKEYS-1:0][KEY_W-1:0] keys,
    output logic [IDX_W-1:0]            idx
);

    logic [NKEYS:0][KEY_W-1:0] fold;

    assign fold[0] = '0;

    generate
        for (genvar k = 0; k < NKEYS; k++) begin : g_fold
            assign fold[k+1] = fold[k] ^ keys[k];
        end
    endgenerate

    assign idx = fold[NKEYS][IDX_W-1:0];

endmodule

// File: rtl/osrl_len_table.sv
module osrl_len_table
    import osrl_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_len,
    output conf_t            rd_conf,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             wr_hit
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][LEN_W-1:0] len;
        logic [DEPTH-1:0][1:0]       conf;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.len[wr_idx]  = wr_len;
            tbl_d.conf[wr_idx] = conf_step(tbl_q.conf[wr_idx], wr_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_len  = tbl_q.len[rd_idx];
    assign rd_conf = tbl_q.conf[rd_idx];

endmodule

// File: rtl/osrl_hist_avg.sv
module osrl_hist_avg #(
    parameter int LEN_W = 16,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    output logic [LEN_W-1:0] mean
);

    localparam int  SUM_W  = LEN_W + $clog2(DEPTH);
    localparam int  SHIFT  = SUM_W + $clog2(DEPTH);
    localparam longint RECIP_L = ((64'sd1 <<< SHIFT) + DEPTH - 1) / DEPTH;
    localparam logic [SHIFT:0] RECIP = RECIP_L[SHIFT:0];
    localparam int  PROD_W = SUM_W + SHIFT + 1;

    typedef struct packed {
        logic [DEPTH-1:0][LEN_W-1:0] slot;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (push) begin
            hist_d.slot[0] = push_len;
            for (int i = 1; i < DEPTH; i++) begin
                hist_d.slot[i] = hist_q.slot[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    logic [SUM_W-1:0]  sum;
    logic [PROD_W-1:0] prod;

    always_comb begin
        sum = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sum = sum + SUM_W'(hist_q.slot[i]);
        end
    end

    // Floor division by DEPTH through a reciprocal multiply.
    assign prod = PROD_W'(sum) * PROD_W'(RECIP);
    assign mean = prod[SHIFT +: LEN_W];

endmodule

// File: rtl/osrl_tol_check.sv
module osrl_tol_check #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] predicted,
    input  logic [LEN_W-1:0] actual,
    output logic             hit
);

    localparam int WIDE_W = LEN_W + 5;

    logic [LEN_W-1:0]  gap;
    logic [WIDE_W-1:0] gap_x20;

    assign gap     = (predicted >= actual) ? (predicted - actual) : (actual - predicted);
    assign gap_x20 = (WIDE_W'(gap) << 4) + (WIDE_W'(gap) << 2);
    assign hit     = gap_x20 <= WIDE_W'(actual);

endmodule

// File: rtl/osrl_predictor.sv
module osrl_predictor
    import osrl_pkg::*;
#(
    parameter int KEY_W      = 64,
    parameter int LEN_W      = 16,
    parameter int IDX_W      = 6,
    parameter int HIST_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_vld,
    input  logic [KEY_W-1:0] key_pstate,
    input  logic [KEY_W-1:0] key_glob0,
    input  logic [KEY_W-1:0] key_glob1,
    input  logic [KEY_W-1:0] key_arg0,
    input  logic [KEY_W-1:0] key_arg1,
    output logic             pred_vld,
    output logic [LEN_W-1:0] pred_len,
    input  logic             exit_vld,
    input  logic [LEN_W-1:0] exit_len
);

    localparam int NKEYS = 5;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] pred;
        logic             vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NKEYS-1:0][KEY_W-1:0] keys;
    logic [IDX_W-1:0]            look_idx;
    logic [LEN_W-1:0]            stored_len;
    conf_t                       stored_conf;
    logic [LEN_W-1:0]            global_mean;
    logic [LEN_W-1:0]            pick;
    logic                        accept_exit;
    logic                        tol_hit;
    logic                        outstanding;

    assign keys = {key_arg1, key_arg0, key_glob1, key_glob0, key_pstate};

    osrl_key_hash #(
        .KEY_W (KEY_W),
        .NKEYS (NKEYS),
        .IDX_W (IDX_W)
    ) u_hash (
        .keys (keys),
        .idx  (look_idx)
    );

    osrl_len_table #(
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (look_idx),
        .rd_len  (stored_len),
        .rd_conf (stored_conf),
        .wr_en   (accept_exit),
        .wr_idx  (ctl_q.idx),
        .wr_len  (exit_len),
        .wr_hit  (tol_hit)
    );

    osrl_hist_avg #(
        .LEN_W (LEN_W),
        .DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept_exit),
        .push_len (exit_len),
        .mean     (global_mean)
    );

    osrl_tol_check #(
        .LEN_W (LEN_W)
    ) u_tol (
        .predicted (ctl_q.pred),
        .actual    (exit_len),
        .hit       (tol_hit)
    );

    assign accept_exit = exit_vld && ctl_q.busy;
    assign pick        = (stored_conf == CONF_MIN) ? global_mean : stored_len;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        if (accept_exit) begin
            ctl_d.busy = 1'b0;
        end
        if (entry_vld) begin
            ctl_d.busy = 1'b1;
            ctl_d.idx  = look_idx;
            ctl_d.pred = pick;
            ctl_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pred_vld    = ctl_q.vld;
    assign pred_len    = ctl_q.pred;
    assign outstanding = ctl_q.busy;

endmodule

// File: rtl/osrl_predictor_chk.sv
module osrl_predictor_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             entry_vld,
    input logic             exit_vld,
    input logic             pred_vld,
    input logic [LEN_W-1:0] pred_len,
    input logic             outstanding
);

    p_vld_after_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_vld |=> pred_vld);

    p_vld_needs_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_vld |=> !pred_vld);

    p_len_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_vld |=> $stable(pred_len));

    p_open_after_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_vld |=> outstanding);

    p_close_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_vld && !entry_vld) |=> !outstanding);

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!outstanding && !entry_vld) |=> !outstanding);

endmodule

bind osrl_predictor osrl_predictor_chk #(
    .LEN_W (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_vld   (entry_vld),
    .exit_vld    (exit_vld),
    .pred_vld    (pred_vld),
    .pred_len    (pred_len),
    .outstanding (outstanding)
);

// File: tb/tb_osrl_predictor.sv
`timescale 1ns/1ps
module tb_osrl_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_vld = 1'b0;
    logic [63:0] key_pstate = '0, key_glob0 = '0, key_glob1 = '0, key_arg0 = '0, key_arg1 = '0;
    logic        pred_vld;
    logic [15:0] pred_len;
    logic        exit_vld = 1'b0;
    logic [15:0] exit_len = '0;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    osrl_predictor dut (
        .clk(clk), .rst_n(rst_n), .entry_vld(entry_vld),
        .key_pstate(key_pstate), .key_glob0(key_glob0), .key_glob1(key_glob1),
        .key_arg0(key_arg0), .key_arg1(key_arg1),
        .pred_vld(pred_vld), .pred_len(pred_len),
        .exit_vld(exit_vld), .exit_len(exit_len)
    );

    typedef struct packed {
        logic [63:0] ps, g0, g1, a0, a1;
        logic [15:0] want;
        logic [15:0] act;
    } vec_t;

    // Expected predictions worked out by hand from R1..R7.
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0,    16'd100},
        '{64'd0, 64'd1, 64'd0, 64'd0, 64'd0, 16'd33,   16'd100},
        '{64'd0, 64'd0, 64'd0, 64'd0, 64'd1, 16'd66,   16'd100},
        '{64'd0, 64'd0, 64'd1, 64'd0, 64'd0, 16'd100,  16'd100},
        '{64'd0, 64'd0, 64'd0, 64'd1, 64'd0, 16'd100,  16'd104},
        '{64'd5, 64'd4, 64'd0, 64'd0, 64'd0, 16'd104,  16'd110},
        '{64'd3, 64'd1, 64'd0, 64'd0, 64'd0, 16'd104,  16'd200},
        '{64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd110,  16'd110},
        '{64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd110,  16'd115},
        '{64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd115,  16'd115},
        '{64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd115,  16'd5000},
        '{64'h8000_0000_0000_0041, 64'd0, 64'd0, 64'd0, 64'd0, 16'd5000, 16'd5000},
        '{64'd0, 64'd0, 64'd2, 64'd0, 64'd0, 16'd3371, 16'd3371},
        '{64'd0, 64'd2, 64'd0, 64'd0, 64'd0, 16'd3371, 16'd3371},
        '{64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd3914, 16'd95},
        '{64'd0, 64'd0, 64'd0, 64'd0, 64'd3, 16'd2279, 16'd95},
        '{64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd1187, 16'd95},
        '{64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd95,   16'd100},
        '{64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd100,  16'd95},
        '{64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd96,   16'd96}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_entry(input logic [63:0] ps, g0, g1, a0, a1,
                            input logic [15:0] want, input string req);
        @(negedge clk);
        key_pstate = ps; key_glob0 = g0; key_glob1 = g1; key_arg0 = a0; key_arg1 = a1;
        entry_vld = 1'b1;
        @(negedge clk);
        entry_vld = 1'b0;
        check({req, " pred_vld"}, 32'(pred_vld), 32'd1);
        check({req, " pred_len"}, 32'(pred_len), 32'(want));
        @(negedge clk);
        check("R2 pred_vld single pulse", 32'(pred_vld), 32'd0);
        check("R2 pred_len held", 32'(pred_len), 32'(want));
    endtask

    task automatic do_exit(input logic [15:0] len);
        @(negedge clk);
        exit_vld = 1'b1;
        exit_len = len;
        @(negedge clk);
        exit_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports
        check("R9 pred_vld after reset", 32'(pred_vld), 32'd0);
        check("R9 pred_len after reset", 32'(pred_len), 32'd0);

        // R1 R3 R4 R5 R6 R7 via the vector table
        for (int v = 0; v < NV; v++) begin
            do_entry(VECS[v].ps, VECS[v].g0, VECS[v].g1, VECS[v].a0, VECS[v].a1,
                     VECS[v].want, $sformatf("R3/R4/R6/R7/R1 vec%0d", v));
            do_exit(VECS[v].act);
        end

        // R8: stray exit must not reach the history; confidence-0 index 10 shows the mean
        do_exit(16'd9999);
        do_entry(64'd10, 64'd0, 64'd0, 64'd0, 64'd0, 16'd97, "R8 stray exit ignored");
        do_exit(16'd97);

        // R8: stray exit must not touch an entry (index 3 holds 96, confidence 1)
        do_exit(16'd7);
        do_entry(64'd0, 64'd0, 64'd0, 64'd3, 64'd0, 16'd96, "R8 entry untouched");
        do_exit(16'd96);

        // R9: a fresh reset clears table and history
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R9 pred_len cleared", 32'(pred_len), 32'd0);
        do_entry(64'd1, 64'd0, 64'd0, 64'd0, 64'd0, 16'd0, "R9 table cleared");
        do_exit(16'd50);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule